// File: doc/BRIEF.md
# PWM and Toggle Timer

This block is a 16-bit timer built from two 8-bit halves, a low half and a high half. Each half has its own prescaler, its own period and duty values, and its own wrap event. A two-bit mode value decides how the halves are combined and what drives the two output pins. The pins are `out_lo` and `out_hi`.

In mode 0 the halves run apart as two toggle timers. In mode 1 they run apart as two PWM channels. In mode 2 they chain into a 16-bit counter whose low half counts rising edges of an external input. In mode 3 they chain into a 16-bit timer clocked by the low prescaler, and the low byte also drives a PWM on `out_lo`.

Software writes seven byte-wide registers through one write port. A write to a period or duty register goes to a shadow copy. The shadow copy reaches the active copy only when that half wraps, so a period that is running is never cut short. A write to the mode register restarts both halves and loads the shadow values at once. Each half has a period flag, a one-cycle pulse that rises on its wrap.

Top module: `pwm_toggle_timer`

## Requirements
- R1: While `rst_n` is low, and until the first wrap after it rises, `out_lo`, `out_hi`, `flag_lo` and `flag_hi` are low. The mode is 0 after reset.
- R2: A half clocked by its prescaler advances once every `pre+1` clock cycles, where `pre` is that half's prescale register.
- R3: In mode 0, each output toggles independently. It toggles once every `(P+1)*(pre+1)` cycles, where `P` is the active period of its own half.
- R4: In mode 1, each output is high while its half's count is below the active duty and low otherwise. Per period it is high for `min(duty, P+1)*(pre+1)` cycles, so a duty of 0 holds it low.
- R5: A period or duty write takes effect at that half's next wrap, and the running period finishes at its old length. A mode write restarts both halves from count 0, loads the shadow values at once, and clears both toggle outputs.
- R6: A flag pulses high for one cycle, one cycle after its half wraps. In modes 2 and 3, `flag_hi` pulses only on the full 16-bit wrap, when the low half wraps while the high half is at its period.
- R7: In mode 2, the low half advances once for each rising edge of `ext_cnt_in`, after a two-flop synchronizer. It does not advance without such an edge.
- R8: In mode 2, `out_lo` toggles on each low-half wrap and `out_hi` toggles on each 16-bit wrap.
- R9: In mode 3, the low half is clocked by the low prescaler and the high half counts low-half wraps. `out_hi` toggles every `(P_lo+1)*(P_hi+1)*(pre_lo+1)` cycles. `out_lo` is the PWM of the low half with the rule of R4. The high prescale value has no effect.
- R10: The register addresses are: 0 mode (data bits 1:0), 1 low prescale, 2 high prescale, 3 low period, 4 high period, 5 low duty, 6 high duty. Reset values: period 255, duty 0, prescale 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (see R10) |
| wr_data | input | HALF_W | Register write data |
| ext_cnt_in | input | 1 | External count input, asynchronous |
| out_lo | output | 1 | Low-half toggle or PWM output |
| out_hi | output | 1 | High-half or 16-bit toggle output, or PWM output |
| flag_lo | output | 1 | Low-half period flag pulse |
| flag_hi | output | 1 | High-half or 16-bit period flag pulse |

## Verification
A counter or active period that is wrong changes the spacing of flag pulses and of toggle edges in the next period, so the bench measures these spacings directly. A duty that is wrong, or a duty that loads at the wrong moment, changes the number of high cycles in every PWM period. The bench counts high cycles over whole periods.

A cascade carry that is wrong first shows at the 16-bit wrap. This is why `flag_hi` and `out_hi` are measured over several full 16-bit periods. A synchronizer or edge detector that is wrong shows as extra or missing low-half wraps within a few pulses.

// File: rtl/ptt_pkg.sv
// Package: shared mode encoding and register addresses for the PWM/toggle timer.
// Assumes a 3-bit register address bus; mode lives in data bits 1:0.
package ptt_pkg;

    typedef enum logic [1:0] {
        MODE_DUAL_TOG = 2'd0,   // two independent toggle timers
        MODE_DUAL_PWM = 2'd1,   // two independent PWM channels
        MODE_CASC_EXT = 2'd2,   // 16-bit chain counting external edges
        MODE_WIDE_PWM = 2'd3    // 16-bit chain on prescaler, low byte PWM
    } ptt_mode_e;

    localparam int          ADDR_W      = 3;
    localparam logic [2:0]  REG_MODE    = 3'd0;
    localparam logic [2:0]  REG_PRE_LO  = 3'd1;
    localparam logic [2:0]  REG_PRE_HI  = 3'd2;
    localparam logic [2:0]  REG_PER_LO  = 3'd3;
    localparam logic [2:0]  REG_PER_HI  = 3'd4;
    localparam logic [2:0]  REG_DUTY_LO = 3'd5;
    localparam logic [2:0]  REG_DUTY_HI = 3'd6;

endpackage

// File: rtl/ptt_prescaler.sv
// Module: programmable clock-enable divider.
// Produces a one-cycle tick every (limit+1) cycles. A restart returns the
// count to zero. Assumes limit may change at any time: the >= compare
// prevents a long wrap-around when limit drops below the current count.
module ptt_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);

    logic [PRE_W-1:0] cnt_q;

    assign tick = (cnt_q >= limit);

    // Divider count: clear on restart or tick, else step by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ptt_edge_sync.sv
// Module: synchronizer and rising-edge detector for an asynchronous input.
// The rise output is a one-cycle pulse STAGES cycles after the input rises.
// Assumes STAGES >= 2 and input pulses wider than one clock.
module ptt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the input through the synchronizer and keep the last stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/ptt_half.sv
// Module: one 8-bit timer half with shadowed period and duty registers.
// Counts 0..period on each step, wraps to 0, and loads shadows into the
// active copies on wrap or restart. A write in the wrap cycle is taken
// into that load. Assumes step is a one-cycle enable.
module ptt_half #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         step,
    input  logic         wr_per,
    input  logic         wr_duty,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt,
    output logic [W-1:0] act_duty,
    output logic         wrap
);

    logic [W-1:0] sh_per_q;
    logic [W-1:0] sh_duty_q;
    logic [W-1:0] act_per_q;
    logic [W-1:0] nxt_per;
    logic [W-1:0] nxt_duty;
    logic [W-1:0] cnt_q;
    logic [W-1:0] duty_q;
    logic         load;

    assign nxt_per  = wr_per  ? wdata : sh_per_q;
    assign nxt_duty = wr_duty ? wdata : sh_duty_q;
    assign wrap     = step && (cnt_q == act_per_q);
    assign load     = restart || wrap;

    // Shadow registers: capture software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_per_q  <= '1;
            sh_duty_q <= '0;
        end else begin
            sh_per_q  <= nxt_per;
            sh_duty_q <= nxt_duty;
        end
    end

    // Active registers: take shadow values only at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_per_q <= '1;
            duty_q    <= '0;
        end else if (load) begin
            act_per_q <= nxt_per;
            duty_q    <= nxt_duty;
        end
    end

    // Period counter: restart clears, step advances or wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    assign cnt      = cnt_q;
    assign act_duty = duty_q;

endmodule

// File: rtl/pwm_toggle_timer.sv
// Module: two 8-bit timer halves arranged by mode into toggle timers,
// PWM channels or a 16-bit chained timer/counter.
// Assumes a synchronous write port; a mode write restarts both halves.
// Half index 0 is the low half, index 1 the high half.
module pwm_toggle_timer #(
    parameter int HALF_W      = 8,
    parameter int PRE_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              ext_cnt_in,
    output logic              out_lo,
    output logic              out_hi,
    output logic              flag_lo,
    output logic              flag_hi
);
    import ptt_pkg::*;

    localparam int NUM_HALVES = 2;

    ptt_mode_e              mode_q;
    logic                   restart;
    logic                   wide_mode;
    logic                   ext_rise;
    logic [NUM_HALVES-1:0]  tick_w;
    logic [NUM_HALVES-1:0]  step_w;
    logic [NUM_HALVES-1:0]  wrap_w;
    logic [NUM_HALVES-1:0]  pwm_w;
    logic [NUM_HALVES-1:0]  tog_en;
    logic [NUM_HALVES-1:0]  tog_q;
    logic [NUM_HALVES-1:0]  flag_q;
    logic [HALF_W-1:0]      cnt_w  [NUM_HALVES];
    logic [HALF_W-1:0]      duty_w [NUM_HALVES];
    logic [HALF_W-1:0]      cnt_lo;

    assign restart   = wr_en && (wr_addr == REG_MODE);
    assign wide_mode = (mode_q == MODE_CASC_EXT) || (mode_q == MODE_WIDE_PWM);

    // Mode register: written through address 0, bits 1:0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_DUAL_TOG;
        end else if (restart) begin
            mode_q <= ptt_mode_e'(wr_data[1:0]);
        end
    end

    ptt_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_ext_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_cnt_in),
        .rise     (ext_rise)
    );

    // Step sources: external edges or low wraps replace the prescaler in chained modes.
    assign step_w[0] = (mode_q == MODE_CASC_EXT) ? ext_rise  : tick_w[0];
    assign step_w[1] = wide_mode                 ? wrap_w[0] : tick_w[1];

    for (genvar i = 0; i < NUM_HALVES; i++) begin : g_half
        localparam logic [2:0] A_PRE  = (i == 0) ? REG_PRE_LO  : REG_PRE_HI;
        localparam logic [2:0] A_PER  = (i == 0) ? REG_PER_LO  : REG_PER_HI;
        localparam logic [2:0] A_DUTY = (i == 0) ? REG_DUTY_LO : REG_DUTY_HI;

        logic [PRE_W-1:0] pre_q;
        logic             wr_per;
        logic             wr_duty;

        assign wr_per  = wr_en && (wr_addr == A_PER);
        assign wr_duty = wr_en && (wr_addr == A_DUTY);

        // Prescale register for this half, effective immediately.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pre_q <= '0;
            end else if (wr_en && (wr_addr == A_PRE)) begin
                pre_q <= wr_data[PRE_W-1:0];
            end
        end

        ptt_prescaler #(
            .PRE_W (PRE_W)
        ) u_pre (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart),
            .limit   (pre_q),
            .tick    (tick_w[i])
        );

        ptt_half #(
            .W (HALF_W)
        ) u_half (
            .clk      (clk),
            .rst_n    (rst_n),
            .restart  (restart),
            .step     (step_w[i]),
            .wr_per   (wr_per),
            .wr_duty  (wr_duty),
            .wdata    (wr_data),
            .cnt      (cnt_w[i]),
            .act_duty (duty_w[i]),
            .wrap     (wrap_w[i])
        );

        assign pwm_w[i] = (cnt_w[i] < duty_w[i]);
    end

    assign cnt_lo = cnt_w[0];

    // Toggle enables: low pin toggles in modes 0 and 2, high pin in all but mode 1.
    assign tog_en[0] = wrap_w[0] && ((mode_q == MODE_DUAL_TOG) || (mode_q == MODE_CASC_EXT));
    assign tog_en[1] = wrap_w[1] && (mode_q != MODE_DUAL_PWM);

    // Toggle state and period flags: flags are one-cycle pulses of the wrap events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q  <= '0;
            flag_q <= '0;
        end else if (restart) begin
            tog_q  <= '0;
            flag_q <= '0;
        end else begin
            tog_q  <= tog_q ^ tog_en;
            flag_q <= wrap_w;
        end
    end

    // Output selection by mode.
    always_comb begin
        out_lo = tog_q[0];
        out_hi = tog_q[1];
        if (mode_q == MODE_DUAL_PWM || mode_q == MODE_WIDE_PWM) begin
            out_lo = pwm_w[0];
        end
        if (mode_q == MODE_DUAL_PWM) begin
            out_hi = pwm_w[1];
        end
    end

    assign flag_lo = flag_q[0];
    assign flag_hi = flag_q[1];

endmodule

// File: rtl/ptt_checker.sv
// Module: property checker for pwm_toggle_timer, attached by bind.
// Observes ports plus mode, restart, low-half count and duty of the top.
module ptt_checker #(
    parameter int HALF_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              restart,
    input logic              ext_rise,
    input logic [HALF_W-1:0] cnt_lo,
    input logic [HALF_W-1:0] duty_lo,
    input logic              out_lo,
    input logic              out_hi,
    input logic              flag_lo,
    input logic              flag_hi
);

    // R1: outputs quiet in the cycle after any reset cycle.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_lo && !out_hi && !flag_lo && !flag_hi))
        else $error("p_reset_quiet_r1");

    // R4: zero active duty holds the low PWM output low.
    p_zero_duty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && duty_lo == '0) |-> !out_lo)
        else $error("p_zero_duty_r4");

    // R3: in mode 0 a change of out_lo is always accompanied by flag_lo.
    p_toggle_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && $stable(mode) && !$past(restart) && (out_lo != $past(out_lo)))
        |-> flag_lo)
        else $error("p_toggle_flag_r3");

    // R6: in chained modes a 16-bit flag coincides with a low-half flag.
    p_wide_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd2 || mode == 2'd3) && $stable(mode) && flag_hi) |-> flag_lo)
        else $error("p_wide_flag_r6");

    // R7: in mode 2 the low count holds without a synchronized edge.
    p_ext_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && $stable(mode) && !$past(ext_rise) && !$past(restart))
        |-> $stable(cnt_lo))
        else $error("p_ext_hold_r7");

endmodule

bind pwm_toggle_timer ptt_checker #(
    .HALF_W (HALF_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_q),
    .restart (restart),
    .ext_rise(ext_rise),
    .cnt_lo  (cnt_lo),
    .duty_lo (duty_w[0]),
    .out_lo  (out_lo),
    .out_hi  (out_hi),
    .flag_lo (flag_lo),
    .flag_hi (flag_hi)
);

// File: tb/pwm_toggle_timer_bench.sv
// Directed bench for pwm_toggle_timer: one task per scenario.
module pwm_toggle_timer_bench;
    import ptt_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ext_cnt_in = 1'b0;
    logic       out_lo, out_hi, flag_lo, flag_hi;

    int checks = 0;
    int fails  = 0;
    int n_flo  = 0;
    int n_fhi  = 0;

    always #2.5 clk = ~clk;

    pwm_toggle_timer u_pwm_toggle_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .ext_cnt_in (ext_cnt_in),
        .out_lo     (out_lo),
        .out_hi     (out_hi),
        .flag_lo    (flag_lo),
        .flag_hi    (flag_hi)
    );

    // Flag pulse counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (flag_lo) n_flo++;
            if (flag_hi) n_fhi++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic pin(input int sel);
        return (sel == 0) ? out_lo : out_hi;
    endfunction

    // Cycles between two consecutive changes of the selected pin.
    task automatic meas_toggle(input int sel, output int n);
        logic v;
        v = pin(sel);
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (pin(sel) != v) break;
        end
        v = pin(sel);
        n = 0;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            n++;
            if (pin(sel) != v) break;
        end
    endtask

    task automatic count_high(input int sel, input int cycles, output int h);
        h = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (pin(sel)) h++;
        end
    endtask

    // Cycles from the current negedge to the next one with flag_lo high.
    task automatic gap_lo(output int n);
        n = 0;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            n++;
            if (flag_lo) break;
        end
    endtask

    task automatic t_reset;
        repeat (4) @(negedge clk);
        check("R1 out_lo in reset", out_lo, 0);
        check("R1 out_hi in reset", out_hi, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 flags after reset", flag_lo | flag_hi, 0);
        check("R1 outputs after reset", out_lo | out_hi, 0);
    endtask

    task automatic t_dual_toggle;
        int n;
        wr(REG_PRE_LO, 8'd0);
        wr(REG_PER_LO, 8'd4);
        wr(REG_PRE_HI, 8'd1);
        wr(REG_PER_HI, 8'd2);
        wr(REG_MODE, 8'd0);
        meas_toggle(0, n);
        check("R3 mode0 low toggle interval", n, 5);
        meas_toggle(1, n);
        check("R2 R3 mode0 high toggle interval with prescale", n, 6);
        n_flo = 0; n_fhi = 0;
        repeat (60) @(negedge clk);
        check("R6 mode0 low flags in 60 cycles", n_flo, 12);
        check("R6 mode0 high flags in 60 cycles", n_fhi, 10);
    endtask

    task automatic t_dual_pwm;
        int h;
        wr(REG_PRE_LO, 8'd0);
        wr(REG_PER_LO, 8'd9);
        wr(REG_DUTY_LO, 8'd3);
        wr(REG_PRE_HI, 8'd2);
        wr(REG_PER_HI, 8'd7);
        wr(REG_DUTY_HI, 8'd0);
        wr(REG_MODE, 8'd1);
        count_high(0, 20, h);
        check("R4 mode1 low high cycles per 2 periods", h, 6);
        count_high(1, 48, h);
        check("R4 mode1 duty 0 keeps high pin low", h, 0);
        wr(REG_DUTY_HI, 8'd5);
        repeat (30) @(negedge clk);
        count_high(1, 48, h);
        check("R2 R4 mode1 high duty 5 prescale 2", h, 30);
        wr(REG_DUTY_LO, 8'd255);
        repeat (15) @(negedge clk);
        count_high(0, 20, h);
        check("R4 mode1 duty above period stays high", h, 20);
    endtask

    task automatic t_shadow;
        int n;
        wr(REG_PRE_LO, 8'd0);
        wr(REG_PER_LO, 8'd9);
        wr(REG_MODE, 8'd0);
        gap_lo(n);
        gap_lo(n);
        wr(REG_PER_LO, 8'd3);
        gap_lo(n);
        check("R5 running period not cut short", n, 8);
        gap_lo(n);
        check("R5 new period after wrap", n, 4);
        wr(REG_PER_LO, 8'd6);
        wr(REG_MODE, 8'd0);
        gap_lo(n);
        check("R5 mode write loads period at once", n, 7);
    endtask

    task automatic ext_pulse;
        @(negedge clk); ext_cnt_in = 1'b1;
        repeat (2) @(negedge clk);
        ext_cnt_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_casc_ext;
        wr(REG_PRE_LO, 8'd0);
        wr(REG_PER_LO, 8'd2);
        wr(REG_PER_HI, 8'd1);
        wr(REG_MODE, 8'd2);
        n_flo = 0; n_fhi = 0;
        repeat (40) @(negedge clk);
        check("R7 no count without external edges", n_flo, 0);
        for (int k = 0; k < 6; k++) ext_pulse();
        repeat (8) @(negedge clk);
        check("R7 low wraps after 6 edges", n_flo, 2);
        check("R6 16-bit flag after 6 edges", n_fhi, 1);
        check("R8 out_lo after two low wraps", out_lo, 0);
        check("R8 out_hi after one 16-bit wrap", out_hi, 1);
        for (int k = 0; k < 3; k++) ext_pulse();
        repeat (8) @(negedge clk);
        check("R8 out_lo after three low wraps", out_lo, 1);
        check("R6 no 16-bit flag on lone low wrap", n_fhi, 1);
    endtask

    task automatic t_wide_pwm;
        int n;
        int h;
        wr(REG_PRE_LO, 8'd0);
        wr(REG_PER_LO, 8'd3);
        wr(REG_DUTY_LO, 8'd2);
        wr(REG_PER_HI, 8'd2);
        wr(REG_PRE_HI, 8'd5);
        wr(REG_MODE, 8'd3);
        meas_toggle(1, n);
        check("R9 mode3 16-bit toggle interval", n, 12);
        count_high(0, 24, h);
        check("R9 mode3 low-byte PWM high cycles", h, 12);
        n_flo = 0; n_fhi = 0;
        repeat (48) @(negedge clk);
        check("R6 mode3 low flags in 48 cycles", n_flo, 12);
        check("R6 R9 mode3 16-bit flags in 48 cycles", n_fhi, 4);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired before completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // R10: all register writes above use the address map of R10.
    initial begin
        t_reset();
        t_dual_toggle();
        t_dual_pwm();
        t_shadow();
        t_casc_ext();
        t_wide_pwm();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule